// File: doc/BRIEF.md
# Half-Bridge Complementary Dead-Time Generator

This block drives the two switch enables of a half-bridge resonant power stage. A period word, counted in system-clock cycles, sets the switching period. The high-side and low-side enables take turns, each for half the period minus a fixed dead interval during which both are low. The result is an exact 50% complementary pattern with a guard band at every edge. A new period word is applied only at the boundary of a full switching cycle, so a half-period in progress is never cut short or stretched.

At every start, the block subtracts a soft-start offset from the commanded period, which raises the frequency. It then removes that offset in equal steps over a fixed interval. A flag stays high while any offset remains. Every start opens with the low-side phase, so the bootstrap supply of the upper switch can charge before the upper switch is driven. Dropping the run input, or raising the fault input, pulls both enables low at the next clock edge. Switching resumes with a fresh soft-start once run is high and fault is low again.

Top module: `hb_deadtime_gen`

## Requirements
- R1: The high-side and low-side enables are never high in the same cycle.
- R2: Every turn-on of either enable follows at least DEAD cycles in which both enables were low. In steady switching, each gap between the two on-phases is exactly DEAD cycles.
- R3: Each on-phase lasts floor(Pe/2) - DEAD cycles. Pe is the effective period: the period word minus the current soft-start offset, raised to MIN_PERIOD when it falls below that value or below zero.
- R4: The period word is sampled once per switching cycle, when the low-side dead interval begins. A change made during a cycle first affects the next low-side phase.
- R5: While run_en is low, both enables are low from the next clock edge on, and ss_active is low.
- R6: A high fault_off forces both enables low at the next clock edge, whatever the phase, including an edge where a dead interval would otherwise end.
- R7: After reset, after a stop or after a fault, the first enable driven high is the low-side one.
- R8: On each start the offset is SS_STEPS*SS_STEP_OFF cycles. It shrinks by SS_STEP_OFF every SS_STEP_CYC cycles. ss_active is high for exactly SS_STEPS*SS_STEP_CYC cycles after the start edge.
- R9: During soft-start the first low-side on-phase is floor((P - SS_STEPS*SS_STEP_OFF)/2) - DEAD cycles, and later on-phases never get shorter while the period word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_word | input | PW | Commanded switching period in clock cycles |
| run_en | input | 1 | High to allow switching |
| fault_off | input | 1 | High forces both enables low |
| hs_drive | output | 1 | High-side switch enable |
| ls_drive | output | 1 | Low-side switch enable |
| ss_active | output | 1 | High while a soft-start offset remains |

## Verification
Two functions can act on the same clock edge: the fault shutdown, and the end of a dead interval, where the sequencer would raise the high-side enable. The bench follows the low-side enable until it falls and counts the dead samples. It raises fault_off in the last dead cycle, so the fault and the scheduled turn-on share one edge, and it requires that the high-side enable never appears. A second overlap occurs when the period word changes in the middle of a cycle. The bench judges it by the length of the high-side phase that is still running, which must keep the old value.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEAD_LO,
    PH_LO_ON,
    PH_DEAD_HI,
    PH_HI_ON
  } hb_phase_t;
endpackage

// File: rtl/hbdt_softstart.sv
module hbdt_softstart #(
  parameter int PW       = 16,
  parameter int STEPS    = 16,
  parameter int STEP_OFF = 18,
  parameter int STEP_CYC = 18750
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          halt,
  output logic          active,
  output logic [PW-1:0] offset
);
  localparam int SW = $clog2(STEPS + 1);
  localparam int TW = $clog2(STEP_CYC + 1);
  localparam logic [SW-1:0] STEPS_L = SW'(STEPS);
  localparam logic [TW-1:0] TMR_TOP = TW'(STEP_CYC - 1);

  logic [SW-1:0] steps_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      steps_q <= '0;
      tmr_q   <= '0;
    end else if (start) begin
      steps_q <= STEPS_L;
      tmr_q   <= TMR_TOP;
    end else if (steps_q != '0) begin
      if (tmr_q == '0) begin
        steps_q <= steps_q - 1'b1;
        tmr_q   <= TMR_TOP;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign active = (steps_q != '0);
  assign offset = PW'(steps_q) * PW'(STEP_OFF);
endmodule

// File: rtl/hbdt_period_calc.sv
module hbdt_period_calc #(
  parameter int PW         = 16,
  parameter int DEAD       = 35,
  parameter int MIN_PERIOD = 334
) (
  input  logic [PW-1:0] period_word,
  input  logic [PW-1:0] offset,
  output logic [PW-1:0] on_len
);
  localparam logic [PW:0] MIN_L = (PW+1)'(MIN_PERIOD);
  logic [PW:0] diff;
  logic [PW:0] eff;

  always_comb begin
    diff = {1'b0, period_word} - {1'b0, offset};
    if (diff[PW] || diff < MIN_L) eff = MIN_L;
    else                          eff = diff;
    on_len = eff[PW:1] - PW'(DEAD);
  end
endmodule

// File: rtl/hbdt_phase_seq.sv
module hbdt_phase_seq
  import hbdt_pkg::*;
#(
  parameter int PW   = 16,
  parameter int DEAD = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [PW-1:0] on_len_in,
  output logic          launch,
  output logic          hi_drv,
  output logic          lo_drv
);
  localparam logic [PW-1:0] DEAD_TOP = PW'(DEAD - 1);

  hb_phase_t     st_q, st_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] on_q, on_d;
  logic          last;

  assign last   = (cnt_q == '0);
  assign launch = go && (st_q == PH_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q - 1'b1;
    on_d  = on_q;
    if (!go) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_d  = PH_DEAD_LO;
          cnt_d = DEAD_TOP;
          on_d  = on_len_in;
        end
        PH_DEAD_LO: if (last) begin
          st_d  = PH_LO_ON;
          cnt_d = on_q - 1'b1;
        end
        PH_LO_ON: if (last) begin
          st_d  = PH_DEAD_HI;
          cnt_d = DEAD_TOP;
        end
        PH_DEAD_HI: if (last) begin
          st_d  = PH_HI_ON;
          cnt_d = on_q - 1'b1;
        end
        PH_HI_ON: if (last) begin
          st_d  = PH_DEAD_LO;
          cnt_d = DEAD_TOP;
          on_d  = on_len_in;
        end
        default: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      on_q   <= '0;
      hi_drv <= 1'b0;
      lo_drv <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      on_q   <= on_d;
      hi_drv <= (st_d == PH_HI_ON);
      lo_drv <= (st_d == PH_LO_ON);
    end
  end
endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
  parameter int PW          = 16,
  parameter int DEAD        = 35,
  parameter int MIN_PERIOD  = 334,
  parameter int SS_STEPS    = 16,
  parameter int SS_STEP_OFF = 18,
  parameter int SS_STEP_CYC = 18750
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period_word,
  input  logic          run_en,
  input  logic          fault_off,
  output logic          hs_drive,
  output logic          ls_drive,
  output logic          ss_active
);
  localparam logic [PW-1:0] FULL_OFF = PW'(SS_STEPS * SS_STEP_OFF);

  logic          go, launch;
  logic [PW-1:0] ss_off, off_use, on_len;

  assign go      = run_en && !fault_off;
  assign off_use = launch ? FULL_OFF : ss_off;

  hbdt_softstart #(
    .PW(PW), .STEPS(SS_STEPS), .STEP_OFF(SS_STEP_OFF), .STEP_CYC(SS_STEP_CYC)
  ) u_ss (
    .clk(clk), .rst(rst), .start(launch), .halt(!go),
    .active(ss_active), .offset(ss_off)
  );

  hbdt_period_calc #(
    .PW(PW), .DEAD(DEAD), .MIN_PERIOD(MIN_PERIOD)
  ) u_calc (
    .period_word(period_word), .offset(off_use), .on_len(on_len)
  );

  hbdt_phase_seq #(
    .PW(PW), .DEAD(DEAD)
  ) u_seq (
    .clk(clk), .rst(rst), .go(go), .on_len_in(on_len),
    .launch(launch), .hi_drv(hs_drive), .lo_drv(ls_drive)
  );
endmodule

// File: rtl/hbdt_checker.sv
module hbdt_checker #(
  parameter int DEAD = 35
) (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic fault_off,
  input logic hs_drive,
  input logic ls_drive,
  input logic ss_active
);
  logic [15:0] off_cnt;
  logic        on_q;
  logic        need_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_cnt <= '0;
      on_q    <= 1'b0;
      need_lo <= 1'b1;
    end else begin
      on_q <= hs_drive || ls_drive;
      if (hs_drive || ls_drive) off_cnt <= '0;
      else if (off_cnt != 16'hFFFF) off_cnt <= off_cnt + 1'b1;
      if (!run_en || fault_off) need_lo <= 1'b1;
      else if (ls_drive)        need_lo <= 1'b0;
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
    !(hs_drive && ls_drive));

  assert_dead_gap_R2: assert property (@(posedge clk) disable iff (rst)
    ((hs_drive || ls_drive) && !on_q) |-> (off_cnt >= 16'(DEAD)));

  assert_stop_low_R5: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!hs_drive && !ls_drive && !ss_active));

  assert_fault_low_R6: assert property (@(posedge clk) disable iff (rst)
    fault_off |=> (!hs_drive && !ls_drive));

  assert_low_first_R7: assert property (@(posedge clk) disable iff (rst)
    hs_drive |-> !need_lo);

  assert_ss_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_active) |-> $past(run_en && !fault_off));
endmodule

bind hb_deadtime_gen hbdt_checker #(.DEAD(DEAD)) u_hbdt_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .fault_off(fault_off),
  .hs_drive(hs_drive), .ls_drive(ls_drive), .ss_active(ss_active)
);

// File: tb/hb_deadtime_gen_test.sv
module hb_deadtime_gen_test;
  localparam int PW = 12, D = 3, MINP = 8, SN = 4, SO = 4, SC = 40;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, flt = 1'b0;
  logic [PW-1:0] pw = 12'd40;
  logic hi, lo, ss;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hb_deadtime_gen #(.PW(PW), .DEAD(D), .MIN_PERIOD(MINP), .SS_STEPS(SN),
    .SS_STEP_OFF(SO), .SS_STEP_CYC(SC)) uut (
    .clk(clk), .rst(rst), .period_word(pw), .run_en(run), .fault_off(flt),
    .hs_drive(hi), .ls_drive(lo), .ss_active(ss));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int on_exp(input int p);
    int e = (p < MINP) ? MINP : p;
    return e / 2 - D;
  endfunction

  task automatic meas(output int l, output int d1, output int h, output int d2);
    @(negedge clk);
    while (lo) @(negedge clk);
    while (!lo) @(negedge clk);
    l = 0;  while (lo) begin l++; @(negedge clk); end
    d1 = 0; while (!hi && !lo) begin d1++; @(negedge clk); end
    h = 0;  while (hi) begin h++; @(negedge clk); end
    d2 = 0; while (!hi && !lo) begin d2++; @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int l, d1, h, d2, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!hi && !lo && !ss, "R5 reset idle", {hi, lo, ss}, 0);

    // soft-start observation (R1 R2 R7 R8 R9)
    begin
      int ss_cnt = 0, cur_lo = 0, cur_dead = 0, first_len = -1, prev_len = 0;
      int both = 0, dead_bad = 0, nondec_bad = 0, last_len = 0;
      bit seen = 0, first_lo = 0;
      pw = 12'd40;
      run = 1'b1;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (hi && lo) both++;
        if (ss) ss_cnt++;
        if (!seen && (hi || lo)) begin seen = 1; first_lo = lo; end
        if (lo) cur_lo++;
        else if (cur_lo > 0) begin
          if (first_len < 0) first_len = cur_lo;
          if (cur_lo < prev_len) nondec_bad++;
          prev_len = cur_lo; last_len = cur_lo; cur_lo = 0;
        end
        if (seen && !hi && !lo) cur_dead++;
        else if (cur_dead > 0) begin
          if (cur_dead != D) dead_bad++;
          cur_dead = 0;
        end
      end
      chk(both == 0, "R1 overlap count", both, 0);
      chk(dead_bad == 0, "R2 dead gaps wrong", dead_bad, 0);
      chk(first_lo, "R7 first phase low-side", first_lo, 1);
      chk(ss_cnt == SN * SC, "R8 soft-start length", ss_cnt, SN * SC);
      chk(first_len == on_exp(40 - SN * SO), "R9 first low on", first_len, on_exp(40 - SN * SO));
      chk(nondec_bad == 0, "R9 on-phase shrank", nondec_bad, 0);
      chk(last_len == on_exp(40), "R8 offset removed", last_len, on_exp(40));
    end

    // steady-state sweep (R2 R3)
    for (int p = 5; p <= 44; p++) begin
      pw = PW'(p);
      meas(l, d1, h, d2);
      meas(l, d1, h, d2);
      chk(l == on_exp(p), $sformatf("R3 low on p=%0d", p), l, on_exp(p));
      chk(h == on_exp(p), $sformatf("R3 high on p=%0d", p), h, on_exp(p));
      chk(d1 == D && d2 == D, $sformatf("R2 dead p=%0d", p), d1 * 100 + d2, D * 101);
    end

    // mid-cycle change (R4)
    pw = 12'd40;
    meas(l, d1, h, d2);
    @(negedge clk);
    while (!lo) @(negedge clk);
    pw = 12'd20;
    while (!hi) @(negedge clk);
    n = 0; while (hi) begin n++; @(negedge clk); end
    chk(n == on_exp(40), "R4 running cycle kept", n, on_exp(40));
    meas(l, d1, h, d2);
    chk(l == on_exp(20), "R4 next cycle new", l, on_exp(20));

    // fault in the middle of a low-side phase (R6, R7)
    pw = 12'd40;
    meas(l, d1, h, d2);
    while (!lo) @(negedge clk);
    flt = 1'b1;
    @(negedge clk);
    chk(!hi && !lo, "R6 fault mid phase", {hi, lo}, 0);
    n = 0;
    repeat (10) begin @(negedge clk); if (hi || lo) n++; end
    chk(n == 0, "R6 held low in fault", n, 0);
    flt = 1'b0;
    @(negedge clk);
    chk(ss, "R8 restart soft-start", ss, 1);
    while (!hi && !lo) @(negedge clk);
    chk(lo && !hi, "R7 low first after fault", lo, 1);

    // fault on the edge a dead gap would end (R6)
    meas(l, d1, h, d2);
    while (!lo) @(negedge clk);
    while (lo) @(negedge clk);
    repeat (D - 1) @(negedge clk);
    flt = 1'b1;
    @(negedge clk);
    chk(!hi, "R6 fault on turn-on edge", hi, 0);
    @(negedge clk);
    flt = 1'b0;

    // stop during high-side phase (R5)
    meas(l, d1, h, d2);
    while (!hi) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(!hi && !lo && !ss, "R5 stop immediate", {hi, lo, ss}, 0);
    n = 0;
    repeat (50) begin
      pw = pw + 12'd1;
      @(negedge clk);
      if (hi || lo || ss) n++;
    end
    chk(n == 0, "R5 stays idle", n, 0);
    pw = 12'd40;
    run = 1'b1;
    while (!hi && !lo) @(negedge clk);
    chk(lo, "R7 low first after stop", lo, 1);
    n = 0; while (lo) begin n++; @(negedge clk); end
    chk(n == on_exp(40 - SN * SO), "R9 restart first on", n, on_exp(40 - SN * SO));

    finish_run();
  end
endmodule